// File: doc/BRIEF.md
# Chip-Select Unit with Programmable Wait-State Acknowledge

This block decodes a processor bus address against a set of programmable address windows and drives one active-low select line for each window that matches. When a bus cycle selects a window, the block can end that cycle itself. It does so by driving the two-line data/size acknowledge after a programmed number of wait clocks. As an alternative, it can hand the acknowledge of an external device through to the processor.

Each channel holds its own configuration, which arrives as static inputs:
- a base address and a window size code;
- a read/write filter;
- an acknowledge mode code;
- a port width bit;
- a choice of the strobe that times its select;
- a flag that says whether the channel's pin is used as a select at all.

A bus cycle opens with the first rising edge at which the address strobe is sampled low. It closes when the strobe is sampled high again.

Top module: `chipSelAck`

## Requirements
- R1: Channel i matches when the address bits at positions 11+sizeCode and above equal the same bits of its base (so a window covers 2^(11+sizeCode) bytes), and its filter allows the access: filter bit 0 allows reads (rdWr=1) and filter bit 1 allows writes (rdWr=0).
- R2: For a channel timed by the address strobe, csN[i] goes low after the first rising edge at which asN is low and the channel matches.
- R3: For a channel timed by the data strobe, csN[i] goes low only after the first rising edge at which both asN and dsN are low.
- R4: For an acknowledge code W from 0 to 13, dsackN is first asserted after the (W+2)th rising edge of the cycle. This makes the cycle 3+W clocks long. The acknowledge then holds until an edge samples asN high.
- R5: Code 14 is fast termination. dsackN is asserted after the first rising edge of the cycle, one clock earlier than with code 0.
- R6: Code 15 selects the external acknowledge. While asN is low, dsackN follows extDsackN one clock later, and the block generates no acknowledge of its own.
- R7: An internal acknowledge is 2'b00 for a channel whose port width bit is 1 (16-bit). It is 2'b10 (only bit 0 low) for a channel whose port width bit is 0 (8-bit).
- R8: A channel whose pin-use flag is 0 keeps its csN bit high at all times, but it still produces its acknowledge.
- R9: Every matching channel drives its select. The acknowledge mode and the port width come from the lowest-numbered matching channel.
- R10: After reset, and after any edge that samples asN high, csN is all ones and dsackN is 2'b11. A cycle that matches no channel produces no acknowledge.
- R11: The wait count restarts on every new assertion of asN, so consecutive cycles get identical acknowledge timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Bus address |
| rdWr | input | 1 | 1 = read, 0 = write |
| asN | input | 1 | Address strobe, active low |
| dsN | input | 1 | Data strobe, active low |
| extDsackN | input | 2 | Acknowledge from an external device, active low |
| cfgBase | input | NUM_CH*ADDR_W | Base address of each channel |
| cfgSize | input | NUM_CH*3 | Window size code of each channel |
| cfgAck | input | NUM_CH*4 | Acknowledge mode code of each channel (0-13 wait, 14 fast, 15 external) |
| cfgPort16 | input | NUM_CH | Port width bit of each channel (1 = 16-bit) |
| cfgUseDs | input | NUM_CH | 1 = time the select from the data strobe |
| cfgRwEn | input | NUM_CH*2 | Access filter of each channel (bit 0 read, bit 1 write) |
| cfgPinCs | input | NUM_CH | 1 = the channel's pin acts as a select |
| csN | output | NUM_CH | Select lines, active low |
| dsackN | output | 2 | Data/size acknowledge, active low |

## Verification
The checker verifies the following on every cycle:
- A sampled-high address strobe releases every select and the acknowledge.
- A channel with its pin unused never drives its select.
- An internal acknowledge stays constant once it has been asserted.
- Fast termination and zero-wait cycles acknowledge after exactly one and exactly two edges.

Only the bench scenarios can show the rest:
- the exact wait count for the larger codes;
- the window size boundaries and the read/write filter;
- the late select for data-strobe timing;
- priority when windows overlap;
- the restart of the count across consecutive cycles.

// File: rtl/chipSelPkg.sv
package chipSelPkg;
  localparam int ACK_W         = 4;
  localparam int SIZE_W        = 3;
  localparam int SIZE_BASE_LOG = 11;
  localparam logic [ACK_W-1:0] ACK_FAST = 4'd14;
  localparam logic [ACK_W-1:0] ACK_EXT  = 4'd15;
  localparam logic [1:0] DSACK_IDLE = 2'b11;
  localparam logic [1:0] DSACK_W16  = 2'b00;
  localparam logic [1:0] DSACK_W8   = 2'b10;

  typedef struct packed {
    logic start;     // first edge of a bus cycle
    logic driveInt;  // drive internal acknowledge at this edge
    logic passExt;   // forward external acknowledge at this edge
    logic port16;    // width of the acknowledging port
  } ctlStrb_t;
endpackage

// File: rtl/chipSelDatapath.sv
module chipSelDatapath
  import chipSelPkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int ADDR_W = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     rdWr,
  input  logic                     asN,
  input  logic                     dsN,
  input  logic [1:0]               extDsackN,
  input  logic [NUM_CH*ADDR_W-1:0] cfgBase,
  input  logic [NUM_CH*SIZE_W-1:0] cfgSize,
  input  logic [NUM_CH*ACK_W-1:0]  cfgAck,
  input  logic [NUM_CH-1:0]        cfgPort16,
  input  logic [NUM_CH-1:0]        cfgUseDs,
  input  logic [NUM_CH*2-1:0]      cfgRwEn,
  input  logic [NUM_CH-1:0]        cfgPinCs,
  input  ctlStrb_t                 strb,
  output logic                     winHit,
  output logic [ACK_W-1:0]         winCode,
  output logic                     winPort16,
  output logic [NUM_CH-1:0]        csN,
  output logic [1:0]               dsackN
);
  logic [NUM_CH-1:0] chHit;
  logic [NUM_CH-1:0] chSel;

  // Per-channel window compare, access filter and select register
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    logic [ADDR_W-1:0] baseVal;
    logic [SIZE_W-1:0] sizeVal;
    logic [ADDR_W-1:0] careMask;
    logic              addrEq;
    logic              rwOk;
    logic              strobeOn;

    assign baseVal = cfgBase[ch*ADDR_W +: ADDR_W];
    assign sizeVal = cfgSize[ch*SIZE_W +: SIZE_W];

    always_comb begin
      for (int b = 0; b < ADDR_W; b++) begin
        careMask[b] = (b >= (SIZE_BASE_LOG + int'(sizeVal)));
      end
    end

    assign addrEq   = (((addr ^ baseVal) & careMask) == '0);
    assign rwOk     = rdWr ? cfgRwEn[ch*2] : cfgRwEn[ch*2+1];
    assign chHit[ch] = addrEq & rwOk;
    assign strobeOn = ~asN & (~cfgUseDs[ch] | ~dsN);
    assign chSel[ch] = chHit[ch] & strobeOn & cfgPinCs[ch];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) csN[ch] <= 1'b1;
      else       csN[ch] <= ~chSel[ch];
    end
  end

  // Lowest-numbered matching channel owns the acknowledge
  always_comb begin
    winHit    = 1'b0;
    winCode   = '0;
    winPort16 = 1'b0;
    for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
      if (chHit[ch]) begin
        winHit    = 1'b1;
        winCode   = cfgAck[ch*ACK_W +: ACK_W];
        winPort16 = cfgPort16[ch];
      end
    end
  end

  // Acknowledge output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dsackN <= DSACK_IDLE;
    else if (strb.driveInt) dsackN <= strb.port16 ? DSACK_W16 : DSACK_W8;
    else if (strb.passExt)  dsackN <= extDsackN;
    else                    dsackN <= DSACK_IDLE;
  end
endmodule

// File: rtl/chipSelControl.sv
module chipSelControl
  import chipSelPkg::*;
#(
  parameter int WAIT_MAX = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             asN,
  input  logic             winHit,
  input  logic [ACK_W-1:0] winCode,
  input  logic             winPort16,
  output ctlStrb_t         strb
);
  localparam int CNT_W = $clog2(WAIT_MAX + 3);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nextCnt;
  logic             liveHit;
  logic [ACK_W-1:0] liveCode;
  logic             livePort16;
  logic             start;
  logic             hitNow;
  logic [ACK_W-1:0] codeNow;
  logic             p16Now;
  logic [CNT_W:0]   target;

  assign start   = ~asN & (cnt == '0);
  assign nextCnt = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  assign hitNow  = start ? winHit    : liveHit;
  assign codeNow = start ? winCode   : liveCode;
  assign p16Now  = start ? winPort16 : livePort16;

  // Edge count at which the acknowledge appears: code+2, fast gives 1
  always_comb begin
    if (codeNow == ACK_FAST) target = (CNT_W+1)'(1);
    else                     target = (CNT_W+1)'(codeNow) + (CNT_W+1)'(2);
  end

  always_comb begin
    strb.start    = start;
    strb.port16   = p16Now;
    strb.passExt  = ~asN & hitNow & (codeNow == ACK_EXT);
    strb.driveInt = ~asN & hitNow & (codeNow != ACK_EXT) &
                    ({1'b0, nextCnt} >= target);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      liveHit    <= 1'b0;
      liveCode   <= '0;
      livePort16 <= 1'b0;
    end else if (asN) begin
      cnt     <= '0;
      liveHit <= 1'b0;
    end else begin
      cnt <= nextCnt;
      if (start) begin
        liveHit    <= winHit;
        liveCode   <= winCode;
        livePort16 <= winPort16;
      end
    end
  end
endmodule

// File: rtl/chipSelAck.sv
module chipSelAck
  import chipSelPkg::*;
#(
  parameter int NUM_CH   = 12,
  parameter int ADDR_W   = 24,
  parameter int WAIT_MAX = 13
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     rdWr,
  input  logic                     asN,
  input  logic                     dsN,
  input  logic [1:0]               extDsackN,
  input  logic [NUM_CH*ADDR_W-1:0] cfgBase,
  input  logic [NUM_CH*3-1:0]      cfgSize,
  input  logic [NUM_CH*4-1:0]      cfgAck,
  input  logic [NUM_CH-1:0]        cfgPort16,
  input  logic [NUM_CH-1:0]        cfgUseDs,
  input  logic [NUM_CH*2-1:0]      cfgRwEn,
  input  logic [NUM_CH-1:0]        cfgPinCs,
  output logic [NUM_CH-1:0]        csN,
  output logic [1:0]               dsackN
);
  ctlStrb_t         strb;
  logic             winHit;
  logic [ACK_W-1:0] winCode;
  logic             winPort16;

  chipSelDatapath #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .addr(addr), .rdWr(rdWr), .asN(asN), .dsN(dsN),
    .extDsackN(extDsackN), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .cfgAck(cfgAck), .cfgPort16(cfgPort16), .cfgUseDs(cfgUseDs),
    .cfgRwEn(cfgRwEn), .cfgPinCs(cfgPinCs), .strb(strb),
    .winHit(winHit), .winCode(winCode), .winPort16(winPort16),
    .csN(csN), .dsackN(dsackN)
  );

  chipSelControl #(.WAIT_MAX(WAIT_MAX)) uCtl (
    .clk(clk), .rstN(rstN), .asN(asN), .winHit(winHit),
    .winCode(winCode), .winPort16(winPort16), .strb(strb)
  );
endmodule

// File: rtl/chipSelAckChk.sv
module chipSelAckChk
  import chipSelPkg::*;
#(
  parameter int NUM_CH = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              asN,
  input logic [NUM_CH-1:0] cfgPinCs,
  input logic [NUM_CH-1:0] csN,
  input logic [1:0]        dsackN,
  input logic              cycStart,
  input logic              winHit,
  input logic [ACK_W-1:0]  winCode
);
  // R10: a sampled-high address strobe releases everything
  p_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    asN |=> (csN == '1 && dsackN == DSACK_IDLE));

  // R8: an unused pin never drives its select
  p_pin_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((~csN & ~cfgPinCs) == '0));

  // R4: an internal acknowledge holds steady while the strobe stays low
  p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && (dsackN == DSACK_W16 || dsackN == DSACK_W8) &&
     !cycStart && winHit && winCode != ACK_EXT)
    |=> (dsackN == $past(dsackN)));

  // R5: fast termination acknowledges after the first edge
  p_fast_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cycStart && winHit && winCode == ACK_FAST) |=> (dsackN != DSACK_IDLE));

  // R4: zero wait acknowledges after the second edge, not the first
  p_zero_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cycStart && winHit && winCode == 4'd0)
    |=> (dsackN == DSACK_IDLE ##1 ($past(asN) || dsackN != DSACK_IDLE)));
endmodule

bind chipSelAck chipSelAckChk #(.NUM_CH(NUM_CH)) uChk (
  .clk(clk), .rstN(rstN), .asN(asN), .cfgPinCs(cfgPinCs), .csN(csN),
  .dsackN(dsackN), .cycStart(strb.start), .winHit(winHit), .winCode(winCode)
);

// File: tb/sim_chipSelAck.sv
module sim_chipSelAck;
  localparam int NUM_CH = 12;
  localparam int ADDR_W = 24;
  localparam int MAXH   = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic rdWr = 1'b1;
  logic asN = 1'b1;
  logic dsN = 1'b1;
  logic [1:0] extDsackN = 2'b11;
  logic [NUM_CH*ADDR_W-1:0] cfgBase = '0;
  logic [NUM_CH*3-1:0] cfgSize = '0;
  logic [NUM_CH*4-1:0] cfgAck = '0;
  logic [NUM_CH-1:0] cfgPort16 = '0;
  logic [NUM_CH-1:0] cfgUseDs = '0;
  logic [NUM_CH*2-1:0] cfgRwEn = '0;
  logic [NUM_CH-1:0] cfgPinCs = '0;
  logic [NUM_CH-1:0] csN;
  logic [1:0] dsackN;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  logic [NUM_CH-1:0] csH [MAXH];
  logic [1:0] dkH [MAXH];
  int firstAck;
  logic relOk;

  always #10 clk = ~clk;

  chipSelAck #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .rdWr(rdWr), .asN(asN), .dsN(dsN),
    .extDsackN(extDsackN), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .cfgAck(cfgAck), .cfgPort16(cfgPort16), .cfgUseDs(cfgUseDs),
    .cfgRwEn(cfgRwEn), .cfgPinCs(cfgPinCs), .csN(csN), .dsackN(dsackN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setCh(input int ch, input logic [ADDR_W-1:0] base, input logic [2:0] size,
                       input logic [3:0] ack, input logic p16, input logic useDs,
                       input logic [1:0] rw, input logic pin);
    cfgBase[ch*ADDR_W +: ADDR_W] = base;
    cfgSize[ch*3 +: 3] = size;
    cfgAck[ch*4 +: 4] = ack;
    cfgPort16[ch] = p16;
    cfgUseDs[ch] = useDs;
    cfgRwEn[ch*2 +: 2] = rw;
    cfgPinCs[ch] = pin;
  endtask

  // One bus cycle: strobe low for nClk edges, data strobe drops after edge dsLag
  task automatic runCycle(input logic [ADDR_W-1:0] a, input logic rd, input int dsLag, input int nClk);
    @(negedge clk);
    addr = a; rdWr = rd; asN = 1'b0; dsN = (dsLag == 0) ? 1'b0 : 1'b1;
    firstAck = 0;
    for (int j = 1; j <= nClk; j++) begin
      @(posedge clk); #1;
      csH[j] = csN; dkH[j] = dsackN;
      if (firstAck == 0 && dsackN != 2'b11) firstAck = j;
      @(negedge clk);
      if (j == dsLag) dsN = 1'b0;
    end
    asN = 1'b1; dsN = 1'b1;
    @(posedge clk); #1;
    relOk = (csN == '1) && (dsackN == 2'b11);
    @(negedge clk);
  endtask

  task automatic tReset;
    chk("R10 reset csN", 32'(csN), 32'hFFF);
    chk("R10 reset dsackN", 32'(dsackN), 32'h3);
  endtask

  task automatic tWaits;
    int codes [4] = '{0, 1, 7, 13};
    foreach (codes[k]) begin
      setCh(0, 24'h000000, 3'd0, 4'(codes[k]), 1'b1, 1'b0, 2'b11, 1'b1);
      runCycle(24'h000100, 1'b1, 0, codes[k] + 4);
      chk("R4 first ack edge", 32'(firstAck), 32'(codes[k] + 2));
      chk("R7 16-bit ack value", 32'(dkH[codes[k] + 2]), 32'h0);
      chk("R4 ack held", 32'(dkH[codes[k] + 4]), 32'h0);
      chk("R2 select after first edge", 32'(csH[1][0]), 32'h0);
      chk("R10 release", 32'(relOk), 32'h1);
    end
  endtask

  task automatic tFast;
    setCh(0, 24'h000000, 3'd0, 4'd14, 1'b1, 1'b0, 2'b11, 1'b1);
    runCycle(24'h000100, 1'b1, 0, 3);
    chk("R5 fast termination edge", 32'(firstAck), 32'h1);
  endtask

  task automatic tPort8;
    setCh(0, 24'h000000, 3'd0, 4'd0, 1'b0, 1'b0, 2'b11, 1'b1);
    runCycle(24'h000100, 1'b1, 0, 3);
    chk("R7 8-bit ack value", 32'(dkH[2]), 32'h2);
  endtask

  task automatic tExt;
    setCh(0, 24'h000000, 3'd0, 4'd15, 1'b1, 1'b0, 2'b11, 1'b1);
    extDsackN = 2'b01;
    runCycle(24'h000100, 1'b1, 0, 3);
    chk("R6 external ack edge", 32'(firstAck), 32'h1);
    chk("R6 external ack value", 32'(dkH[2]), 32'h1);
    extDsackN = 2'b11;
    runCycle(24'h000100, 1'b1, 0, 5);
    chk("R6 no internal ack", 32'(firstAck), 32'h0);
    setCh(0, 24'h000000, 3'd0, 4'd0, 1'b1, 1'b0, 2'b00, 1'b1);
  endtask

  task automatic tDsQual;
    setCh(1, 24'h010000, 3'd0, 4'd0, 1'b1, 1'b1, 2'b11, 1'b1);
    runCycle(24'h010004, 1'b1, 2, 4);
    chk("R3 select waits edge1", 32'(csH[1][1]), 32'h1);
    chk("R3 select waits edge2", 32'(csH[2][1]), 32'h1);
    chk("R3 select after data strobe", 32'(csH[3][1]), 32'h0);
    setCh(1, 24'h010000, 3'd0, 4'd0, 1'b1, 1'b1, 2'b00, 1'b1);
  endtask

  task automatic tPinOff;
    setCh(2, 24'h020000, 3'd0, 4'd1, 1'b1, 1'b0, 2'b11, 1'b0);
    runCycle(24'h020010, 1'b1, 0, 4);
    chk("R8 pin unused stays high", 32'(csH[3][2]), 32'h1);
    chk("R8 ack still produced", 32'(firstAck), 32'h3);
    setCh(2, 24'h020000, 3'd0, 4'd1, 1'b1, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic tPriority;
    setCh(3, 24'h040000, 3'd3, 4'd5, 1'b1, 1'b0, 2'b11, 1'b1);
    setCh(4, 24'h041000, 3'd0, 4'd0, 1'b0, 1'b0, 2'b11, 1'b1);
    runCycle(24'h041010, 1'b1, 0, 8);
    chk("R9 both selects ch3", 32'(csH[1][3]), 32'h0);
    chk("R9 both selects ch4", 32'(csH[1][4]), 32'h0);
    chk("R9 lowest channel timing", 32'(firstAck), 32'h7);
    chk("R9 lowest channel width", 32'(dkH[7]), 32'h0);
  endtask

  task automatic tNoMatch;
    runCycle(24'h300000, 1'b1, 0, 4);
    chk("R10 no select", 32'(csH[2]), 32'hFFF);
    chk("R10 no ack", 32'(firstAck), 32'h0);
  endtask

  task automatic tRwFilter;
    setCh(5, 24'h050000, 3'd0, 4'd0, 1'b1, 1'b0, 2'b01, 1'b1);
    runCycle(24'h050000, 1'b0, 0, 3);
    chk("R1 write filtered select", 32'(csH[1][5]), 32'h1);
    chk("R1 write filtered ack", 32'(firstAck), 32'h0);
    runCycle(24'h050000, 1'b1, 0, 3);
    chk("R1 read allowed", 32'(csH[1][5]), 32'h0);
  endtask

  task automatic tSize;
    setCh(6, 24'h060000, 3'd1, 4'd0, 1'b1, 1'b0, 2'b11, 1'b1);
    runCycle(24'h060FFE, 1'b1, 0, 2);
    chk("R1 inside window", 32'(csH[1][6]), 32'h0);
    runCycle(24'h061000, 1'b1, 0, 2);
    chk("R1 past window", 32'(csH[1][6]), 32'h1);
  endtask

  task automatic tBackToBack;
    setCh(0, 24'h000000, 3'd0, 4'd3, 1'b1, 1'b0, 2'b11, 1'b1);
    runCycle(24'h000010, 1'b1, 0, 7);
    chk("R11 first cycle timing", 32'(firstAck), 32'h5);
    runCycle(24'h000020, 1'b0, 0, 7);
    chk("R11 second cycle timing", 32'(firstAck), 32'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset;
    tWaits;
    tFast;
    tPort8;
    tExt;
    tDsQual;
    tPinOff;
    tPriority;
    tNoMatch;
    tRwFilter;
    tSize;
    tBackToBack;
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule